// File: doc/BRIEF.md
# SAR Conversion Controller

This block sequences the digital half of a 14-bit successive-approximation converter. While idle it keeps the analog front end in the acquire phase, with the sample switches closed and comparator zeroing active. It counts a minimum acquisition interval, given in clock cycles. A start request is made by driving chip-select and convert-start high together. Once the interval has elapsed, the request moves the front end into hold, clears the approximation register and resolves one bit per two clock cycles, starting at the MSB.

Each bit is first set in the trial code driven to the capacitive DAC. The comparator then has one cycle to settle. If the comparator reports that the held input is below the trial code, the bit is dropped again. After the LSB, the resolved word is copied into a separate output latch, which keeps the previous result until that moment. A one-cycle done pulse marks the new value. Requests made during a conversion are discarded. A request made during acquisition but before the interval has elapsed is remembered and served as soon as the interval ends.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion is accepted only when cs_i and conv_i are both high (active high) in the same cycle. Either one alone never starts a conversion.
- R2: The approximation register is all zeros in the first busy cycle of every conversion, as seen on trial_o.
- R3: A start request made while busy_o is high is discarded. It neither restarts the running conversion nor starts another one after done_o.
- R4: Bits are tried from bit 13 down to bit 0. In the second busy cycle trial_o is exactly bit 13 set. A bit is cleared when cmp_below_i is high (input below trial code). With an ideal comparator, data_o equals the input code.
- R5: While idle, sample_o=1, zero_o=1 and hold_o=0. While busy, sample_o=0, zero_o=0 and hold_o=1.
- R6: At least ACQ_CYCLES cycles of acquire phase pass between the cycle after one conversion ends (or reset is released) and the next busy cycle. A request that is held or waiting starts the conversion exactly ACQ_CYCLES cycles after done_o rises.
- R7: data_o keeps the previous result through a conversion and changes only in the cycle in which done_o rises.
- R8: busy_o is high for exactly 2*WIDTH+1 cycles (29). done_o is high for exactly one cycle, in the first cycle with busy_o low, and data_o is already updated in that cycle.
- R9: A start request made during the acquire phase before the interval has elapsed is held pending, even if the inputs drop, and is served when the interval ends.
- R10: After reset, data_o=0, busy_o=0, done_o=0, and the block is in the acquire phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| conv_i | input | 1 | Convert-start request, active high |
| cmp_below_i | input | 1 | Comparator result: 1 when the held input is below the trial code |
| trial_o | output | 14 | Trial code to the capacitive DAC |
| sample_o | output | 1 | Close the input sample switches |
| hold_o | output | 1 | Switch the sampled charge into hold/convert |
| zero_o | output | 1 | Comparator offset zeroing |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse after the output latch update |
| data_o | output | 14 | Latched conversion result |

## Verification
Some properties are checked by assertions on every cycle. These are the phase signals during busy, that the acquisition counter stays within its bound, that every accepted start follows a completed interval, that the register is cleared at start, and that the trial bits below the current bit stay untouched. The assertions also check that the output latch holds its value outside a load and that done is a single-cycle pulse. Other behaviour can only be shown by the bench scenarios. These are the resolved value for a given input, the exact length of busy, the distance from done to the next start for waiting and held requests, the discarding of requests made during a conversion, and the rejection of a partial chip-select/convert-start pair.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_SET   = 2'd1,
    ST_EVAL  = 2'd2,
    ST_LATCH = 2'd3
  } conv_state_e;
endpackage

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
  parameter int ACQ_CYCLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic ready_o
);
  localparam int CNT_W = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ACQ_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  // counter restarts whenever acquire phase is left
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = run_i && (cnt_q == LIMIT);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT); // R6
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int WIDTH = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic             eval_i,
  input  logic             cmp_below_i,
  output logic [WIDTH-1:0] code_o,
  output logic             last_o
);
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(WIDTH - 1);

  logic [WIDTH-1:0] code_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] low_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      idx_q  <= MSB_IDX;
    end else if (clr_i) begin
      code_q <= '0;
      idx_q  <= MSB_IDX;
    end else if (set_i) begin
      code_q[idx_q] <= 1'b1;
    end else if (eval_i) begin
      if (cmp_below_i) code_q[idx_q] <= 1'b0;
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign code_o   = code_q;
  assign last_o   = (idx_q == '0);
  assign low_mask = (WIDTH'(1) << idx_q) - WIDTH'(1);

  AST_SAR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (code_q == '0)); // R2
  AST_LOWER_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |-> ((code_q & low_mask) == '0)); // R4
  AST_TRIAL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |-> code_q[idx_q]); // R4
endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
  parameter int WIDTH = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] data_o,
  output logic             done_o
);
  logic [WIDTH-1:0] data_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= load_i;
      if (load_i) data_q <= code_i;
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(data_q)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int WIDTH      = 14,
  parameter int ACQ_CYCLES = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             conv_i,
  input  logic             cmp_below_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             sample_o,
  output logic             hold_o,
  output logic             zero_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] data_o
);
  conv_state_e state_q, state_d;
  logic        pend_q;
  logic        req;
  logic        in_acq;
  logic        acq_ready;
  logic        accept;
  logic        last_bit;
  logic [WIDTH-1:0] code;

  assign req    = cs_i & conv_i;
  assign in_acq = (state_q == ST_ACQ);
  assign accept = in_acq && acq_ready && (req || pend_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACQ:   if (accept) state_d = ST_SET;
      ST_SET:   state_d = ST_EVAL;
      ST_EVAL:  state_d = last_bit ? ST_LATCH : ST_SET;
      ST_LATCH: state_d = ST_ACQ;
      default:  state_d = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACQ;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // early request waits for the acquire interval; requests while busy are dropped
      if (accept)            pend_q <= 1'b0;
      else if (in_acq && req) pend_q <= 1'b1;
    end
  end

  sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (in_acq),
    .ready_o (acq_ready)
  );

  sar_bit_engine #(.WIDTH(WIDTH)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .set_i       (state_q == ST_SET),
    .eval_i      (state_q == ST_EVAL),
    .cmp_below_i (cmp_below_i),
    .code_o      (code),
    .last_o      (last_bit)
  );

  sar_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_LATCH),
    .code_i (code),
    .data_o (data_o),
    .done_o (done_o)
  );

  assign trial_o  = code;
  assign sample_o = in_acq;
  assign zero_o   = in_acq;
  assign hold_o   = !in_acq;
  assign busy_o   = !in_acq;

  AST_START_AFTER_ACQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(acq_ready)); // R6
  AST_BUSY_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (hold_o && !sample_o && !zero_o)); // R5
  AST_LATCH_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH) |-> last_bit); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R8
endmodule

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  localparam int W        = 14;
  localparam int ACQ      = 10;
  localparam int CONV_LEN = 2 * W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, conv = 1'b0;
  logic [W-1:0] vin = '0;
  logic [W-1:0] trial, data;
  logic sample, hold, zero, busy, done;
  logic cmp_below;

  int errs = 0, checks = 0;
  bit summary_done = 0;
  logic [W-1:0] last_res = '0;

  always #10 clk = ~clk;

  assign cmp_below = (vin < trial); // ideal comparator

  sar_conv_ctrl #(.WIDTH(W), .ACQ_CYCLES(ACQ)) u_sar_conv_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .conv_i(conv),
    .cmp_below_i(cmp_below), .trial_o(trial), .sample_o(sample),
    .hold_o(hold), .zero_o(zero), .busy_o(busy), .done_o(done), .data_o(data)
  );

  function automatic logic [W-1:0] expected_code(input logic [W-1:0] v);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
    end
  endtask

  // from first busy negedge to the done negedge
  task automatic track_conv(input logic [W-1:0] v, input bit retrig);
    int n;
    logic [W-1:0] exp_v;
    exp_v = expected_code(v);
    chk(trial == '0, "R2 trial at start", int'(trial), 0);
    chk(hold && !sample && !zero, "R5 busy phase", {29'd0, hold, sample, zero}, 4);
    n = 1;
    @(negedge clk);
    if (busy) n++;
    chk(trial == (W'(1) << (W - 1)), "R4 msb trial", int'(trial), 1 << (W - 1));
    while (busy && n < 100) begin
      @(negedge clk);
      if (retrig && n == 5) begin cs = 1'b1; conv = 1'b1; end
      if (retrig && n == 9) begin cs = 1'b0; conv = 1'b0; end
      if (n == 12) chk(data == last_res, "R7 latch holds", int'(data), int'(last_res));
      if (busy) n++;
    end
    chk(n == CONV_LEN, "R8 busy length", n, CONV_LEN);
    chk(done, "R8 done pulse", int'(done), 1);
    chk(data == exp_v, "R4 result", int'(data), int'(exp_v));
    last_res = exp_v;
  endtask

  task automatic start_and_track(input logic [W-1:0] v, input bit retrig);
    int k;
    vin = v;
    @(negedge clk);
    cs = 1'b1; conv = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!busy && k < 200);
    cs = 1'b0; conv = 1'b0;
    track_conv(v, retrig);
  endtask

  task automatic done_drops();
    @(negedge clk);
    chk(!done, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int k;
    bit seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(data == '0 && !busy && !done, "R10 reset outputs", int'(data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample && zero && !hold, "R10/R5 acquire after reset", {29'd0, sample, zero, hold}, 6);

    // R1: partial requests
    cs = 1'b1; conv = 1'b0; seen = 0;
    repeat (30) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R1 cs only", int'(seen), 0);
    cs = 1'b0; conv = 1'b1;
    repeat (30) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R1 conv only", int'(seen), 0);
    conv = 1'b0;
    chk(data == '0, "R1 no result", int'(data), 0);

    // directed corner codes
    start_and_track(W'(0), 0);       done_drops();
    start_and_track({W{1'b1}}, 0);   done_drops();
    start_and_track(W'(1 << (W-1)), 0); done_drops();
    start_and_track(W'((1 << (W-1)) - 1), 0); done_drops();
    start_and_track(W'(1), 0);       done_drops();

    // R3: request during conversion is dropped
    start_and_track(W'(12345), 1);
    seen = 0;
    repeat (ACQ + 8) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R3 no retrigger", int'(seen), 0);

    // R9: one-cycle request just after done is held pending
    start_and_track(W'(777), 0);
    vin = W'(4242);
    cs = 1'b1; conv = 1'b1;
    @(negedge clk);
    chk(!done, "R8 done one cycle", int'(done), 0);
    cs = 1'b0; conv = 1'b0;
    k = 1;
    while (!busy && k < 200) begin @(negedge clk); k++; end
    chk(k == ACQ, "R9 pending start delay", k, ACQ);
    track_conv(W'(4242), 0);

    // R6: held request waits exactly the acquire interval
    vin = W'(9001);
    cs = 1'b1; conv = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!busy && k < 200);
    cs = 1'b0; conv = 1'b0;
    chk(k == ACQ, "R6 min acquire", k, ACQ);
    track_conv(W'(9001), 0);
    done_drops();

    // random codes
    for (int i = 0; i < 30; i++) begin
      start_and_track(W'($urandom), 0);
      done_drops();
      repeat ($urandom_range(0, 15)) @(negedge clk);
    end

    summary();
    $finish;
  end
endmodule